// File: doc/BRIEF.md
# Programmable Clock Divider Bank

The bank turns one stable master clock into a set of slower clock-enable strobes for switched-capacitor processing blocks. A primary divider counts master cycles and emits one strobe every R master cycles. Several secondary channels count those primary strobes. Each channel can be enabled, has its own ratio, and can start a set number of primary strobes late. This start delay is how channels are placed in phase relative to one another. A separate auto-zero divider counts master cycles and emits a slow tick for offset-cancellation cycles.

The bank also flags every primary strobe on which all enabled channels strobe together. Those alignment points are the only moments at which a new configuration is adopted. A configuration that differs from the active one is held back until the next alignment. The whole bank then restarts from zero with the new settings, so no shortened or stretched period ever appears on a channel.

Every strobe is registered, and the outputs run one master cycle behind the counter state that produces them.

Top module: `clkdiv_bank`

## Requirements
- R1: `pri_tick_o` is high once every Rp master cycles, where Rp is `pri_ratio_i`. A ratio field of 0 acts as 1, and a ratio of 1 gives a strobe on every cycle. Counting from the restart point, the k-th cycle (k from 0) strobes when k mod Rp = Rp-1.
- R2: Each enabled secondary channel strobes only on a cycle that carries a primary strobe. After its delay, the channel strobes once every Rs primary strobes, where Rs is the channel's field in `sec_ratio_i` (RATIO_W bits, channel i at bits i*RATIO_W and up). A field of 0 acts as 1.
- R3: A channel with phase P skips the first P primary strobes after a restart. The phase is the channel's field in `sec_phase_i` (PHASE_W bits, channel i at bits i*PHASE_W and up). Counting primary strobes from 0, the channel strobes on index m when m ≥ P and (m-P) mod Rs = Rs-1.
- R4: A channel whose bit in `sec_en_i` is 0 in the active configuration never strobes.
- R5: `aligned_o` is high exactly on those primary strobes where every enabled channel also strobes. If no channel is enabled, `aligned_o` is high on every primary strobe.
- R6: A change of configuration takes effect only at an alignment point. The configuration covers `pri_ratio_i`, `sec_ratio_i`, `sec_phase_i` and `sec_en_i`, compared field by field as raw values. If the inputs differ from the active configuration on an aligned cycle, the next cycle counts from zero with the inputs, as after reset. If they are equal, counting simply continues.
- R7: `az_tick_o` is high once every A master cycles, where A = max(`az_ratio_i`, AZ_MIN). A new value of `az_ratio_i` is adopted at each auto-zero tick, and the next period uses it.
- R8: While `rst` is high, all outputs are low and the input configuration is loaded as the active one. Every output is registered, so the strobe of counter cycle k appears on the output during cycle k+1. The cycle ending at the first rising edge with `rst` low is cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_ratio_i | input | RATIO_W | Primary division ratio (0 acts as 1) |
| sec_ratio_i | input | N_SEC*RATIO_W | Secondary ratios, one field per channel |
| sec_phase_i | input | N_SEC*PHASE_W | Secondary start delays in primary strobes |
| sec_en_i | input | N_SEC | Secondary channel enables |
| az_ratio_i | input | AZ_W | Auto-zero ratio in master cycles, raised to AZ_MIN |
| pri_tick_o | output | 1 | Primary clock-enable strobe |
| sec_tick_o | output | N_SEC | Secondary clock-enable strobes |
| az_tick_o | output | 1 | Auto-zero tick |
| aligned_o | output | 1 | All enabled channels strobed together |

## Verification
Every output is due exactly one master cycle after the counter state that produces it. The bench therefore samples on the falling edge and compares the j-th sample after reset release against the closed-form value for counter cycle j-1.

A configuration change made before an edge is judged on that edge's aligned cycle. From the following cycle, the expected strobes are computed from a new zero point. Auto-zero reloads are tracked the same way, from the cycle after each tick.

During reset, all outputs are checked low on every sampled cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Terminal count of a divider: a ratio field of zero behaves as one.
  function automatic int unsigned ratio_top(input int unsigned r);
    return (r == 0) ? 0 : r - 1;
  endfunction

  // Auto-zero ratio with the floor applied.
  function automatic int unsigned az_floor(input int unsigned r, input int unsigned lo);
    return (r < lo) ? lo : r;
  endfunction

endpackage

// File: rtl/clkdiv_primary.sv
module clkdiv_primary #(
  parameter int RATIO_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [RATIO_W-1:0] ratio,
  output logic               ce
);
  import clkdiv_pkg::*;

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] top_val;

  assign top_val = RATIO_W'(ratio_top(32'(ratio)));
  assign ce      = (cnt_q == top_val);

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt_q <= '0;
    else if (ce)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/clkdiv_secondary.sv
module clkdiv_secondary #(
  parameter int RATIO_W = 9,
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               pri_ce,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [PHASE_W-1:0] phase_ld,
  output logic               ce
);
  import clkdiv_pkg::*;

  logic [PHASE_W-1:0] dly_q;
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] top_val;
  logic               running;

  assign top_val = RATIO_W'(ratio_top(32'(ratio)));
  assign running = (dly_q == '0);
  assign ce      = en && pri_ce && running && (cnt_q == top_val);

  // The delay counter burns primary strobes first; only then does the
  // ratio counter advance. Disabled channels hold a fresh start state.
  always_ff @(posedge clk) begin
    if (rst || restart || !en) begin
      dly_q <= phase_ld;
      cnt_q <= '0;
    end else if (pri_ce) begin
      if (!running)
        dly_q <= dly_q - 1'b1;
      else if (cnt_q == top_val)
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/clkdiv_autozero.sv
module clkdiv_autozero #(
  parameter int AZ_W   = 19,
  parameter int AZ_MIN = 1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AZ_W-1:0] ratio_in,
  output logic            ce
);
  import clkdiv_pkg::*;

  logic [AZ_W-1:0] ratio_q;
  logic [AZ_W-1:0] cnt_q;
  logic [AZ_W-1:0] ratio_fl;

  assign ratio_fl = AZ_W'(az_floor(32'(ratio_in), AZ_MIN));
  assign ce       = (cnt_q == ratio_q - 1'b1);

  // The ratio is sampled only at a period boundary.
  always_ff @(posedge clk) begin
    if (rst || ce) begin
      ratio_q <= ratio_fl;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int N_SEC   = 4,
  parameter int RATIO_W = 9,
  parameter int PHASE_W = 8,
  parameter int AZ_W    = 19,
  parameter int AZ_MIN  = 1000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [RATIO_W-1:0]         pri_ratio_i,
  input  logic [N_SEC*RATIO_W-1:0]   sec_ratio_i,
  input  logic [N_SEC*PHASE_W-1:0]   sec_phase_i,
  input  logic [N_SEC-1:0]           sec_en_i,
  input  logic [AZ_W-1:0]            az_ratio_i,
  output logic                       pri_tick_o,
  output logic [N_SEC-1:0]           sec_tick_o,
  output logic                       az_tick_o,
  output logic                       aligned_o
);
  localparam int CFG_W = RATIO_W + N_SEC * (RATIO_W + PHASE_W + 1);

  logic [RATIO_W-1:0]       pri_ratio_q;
  logic [N_SEC*RATIO_W-1:0] sec_ratio_q;
  logic [N_SEC*PHASE_W-1:0] sec_phase_q;
  logic [N_SEC-1:0]         sec_en_q;

  logic [CFG_W-1:0]         cfg_in;
  logic [CFG_W-1:0]         cfg_act;
  logic                     cfg_diff;
  logic                     restart;
  logic [N_SEC*PHASE_W-1:0] phase_next;

  logic                     pri_ce;
  logic [N_SEC-1:0]         sec_ce;
  logic                     align_s;
  logic                     az_ce;

  assign cfg_in     = {pri_ratio_i, sec_ratio_i, sec_phase_i, sec_en_i};
  assign cfg_act    = {pri_ratio_q, sec_ratio_q, sec_phase_q, sec_en_q};
  assign cfg_diff   = (cfg_in != cfg_act);
  assign align_s    = pri_ce && (&(sec_ce | ~sec_en_q));
  assign restart    = align_s && cfg_diff;
  assign phase_next = (rst || restart) ? sec_phase_i : sec_phase_q;

  // Active configuration: loaded in reset and at a differing alignment.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pri_ratio_q <= pri_ratio_i;
      sec_ratio_q <= sec_ratio_i;
      sec_phase_q <= sec_phase_i;
      sec_en_q    <= sec_en_i;
    end
  end

  clkdiv_primary #(.RATIO_W(RATIO_W)) pri_i (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .ratio   (pri_ratio_q),
    .ce      (pri_ce)
  );

  for (genvar g = 0; g < N_SEC; g++) begin : g_sec
    clkdiv_secondary #(.RATIO_W(RATIO_W), .PHASE_W(PHASE_W)) sec_i (
      .clk      (clk),
      .rst      (rst),
      .restart  (restart),
      .pri_ce   (pri_ce),
      .en       (sec_en_q[g]),
      .ratio    (sec_ratio_q[g*RATIO_W +: RATIO_W]),
      .phase_ld (phase_next[g*PHASE_W +: PHASE_W]),
      .ce       (sec_ce[g])
    );
  end

  clkdiv_autozero #(.AZ_W(AZ_W), .AZ_MIN(AZ_MIN)) az_i (
    .clk      (clk),
    .rst      (rst),
    .ratio_in (az_ratio_i),
    .ce       (az_ce)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_tick_o <= 1'b0;
      sec_tick_o <= '0;
      az_tick_o  <= 1'b0;
      aligned_o  <= 1'b0;
    end else begin
      pri_tick_o <= pri_ce;
      sec_tick_o <= sec_ce;
      az_tick_o  <= az_ce;
      aligned_o  <= align_s;
    end
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int N_SEC   = 4,
  parameter int RATIO_W = 9,
  parameter int AZ_W    = 19,
  parameter int AZ_MIN  = 1000
) (
  input logic               clk,
  input logic               rst,
  input logic               pri_tick_o,
  input logic [N_SEC-1:0]   sec_tick_o,
  input logic               az_tick_o,
  input logic               aligned_o,
  input logic [N_SEC-1:0]   en_q,
  input logic [RATIO_W-1:0] pri_ratio_q
);
  logic            live_q;
  logic            seen_q;
  logic [AZ_W:0]   gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      live_q <= 1'b1;
      if (az_tick_o) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
      end else if (gap_q < (AZ_W+1)'(AZ_MIN)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  p_unity_pri_r1: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(pri_ratio_q) <= 1) |-> pri_tick_o);

  p_sec_on_pri_r2: assert property (@(posedge clk) disable iff (rst)
    (sec_tick_o != '0) |-> pri_tick_o);

  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    live_q |-> ((sec_tick_o & ~$past(en_q)) == '0));

  p_aligned_pri_r5: assert property (@(posedge clk) disable iff (rst)
    aligned_o |-> pri_tick_o);

  p_aligned_all_r5: assert property (@(posedge clk) disable iff (rst)
    (live_q && aligned_o) |-> (&(sec_tick_o | ~$past(en_q))));

  p_az_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (seen_q && az_tick_o) |-> (gap_q >= (AZ_W+1)'(AZ_MIN - 1)));
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
  .N_SEC   (N_SEC),
  .RATIO_W (RATIO_W),
  .AZ_W    (AZ_W),
  .AZ_MIN  (AZ_MIN)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .pri_tick_o  (pri_tick_o),
  .sec_tick_o  (sec_tick_o),
  .az_tick_o   (az_tick_o),
  .aligned_o   (aligned_o),
  .en_q        (sec_en_q),
  .pri_ratio_q (pri_ratio_q)
);

// File: tb/clkdiv_bank_tb_top.sv
module clkdiv_bank_tb_top;
  localparam int N   = 3;
  localparam int RW  = 4;
  localparam int PW  = 3;
  localparam int AW  = 8;
  localparam int AZM = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [RW-1:0]   pri_ratio;
  logic [N*RW-1:0] sec_ratio;
  logic [N*PW-1:0] sec_phase;
  logic [N-1:0]    sec_en;
  logic [AW-1:0]   az_ratio;
  logic            pri_tick;
  logic [N-1:0]    sec_tick;
  logic            az_tick;
  logic            aligned;

  int cur_rp, cur_en, cur_az;
  int cur_rs [N];
  int cur_ph [N];

  int act_rp, act_en, base, az_a, az_base, k, restarts;
  int act_rs [N];
  int act_ph [N];
  int tests, fails;

  always_comb begin
    pri_ratio = RW'(cur_rp);
    sec_en    = N'(cur_en);
    az_ratio  = AW'(cur_az);
    for (int i = 0; i < N; i++) begin
      sec_ratio[i*RW +: RW] = RW'(cur_rs[i]);
      sec_phase[i*PW +: PW] = PW'(cur_ph[i]);
    end
  end

  clkdiv_bank #(.N_SEC(N), .RATIO_W(RW), .PHASE_W(PW), .AZ_W(AW), .AZ_MIN(AZM)) dut_i (
    .clk(clk), .rst(rst), .pri_ratio_i(pri_ratio), .sec_ratio_i(sec_ratio),
    .sec_phase_i(sec_phase), .sec_en_i(sec_en), .az_ratio_i(az_ratio),
    .pri_tick_o(pri_tick), .sec_tick_o(sec_tick), .az_tick_o(az_tick), .aligned_o(aligned)
  );

  function automatic int eff(input int r);
    return (r == 0) ? 1 : r;
  endfunction

  function automatic int azf(input int r);
    return (r < AZM) ? AZM : r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, k, act, exp);
    end
  endtask

  task automatic adopt();
    act_rp = cur_rp;
    act_en = cur_en;
    for (int i = 0; i < N; i++) begin
      act_rs[i] = cur_rs[i];
      act_ph[i] = cur_ph[i];
    end
  endtask

  function automatic bit same_cfg();
    bit s;
    s = (act_rp == cur_rp) && (act_en == cur_en);
    for (int i = 0; i < N; i++)
      if (act_rs[i] != cur_rs[i] || act_ph[i] != cur_ph[i]) s = 1'b0;
    return s;
  endfunction

  // R8: reset holds outputs low, then the model starts at cycle 0
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R8 outputs in reset", {pri_tick, sec_tick, az_tick, aligned}, 0);
    end
    rst = 1'b0;
    adopt();
    base = 0; az_base = 0; az_a = azf(cur_az); k = 0;
  endtask

  task automatic step(input string ctx);
    int rel, rp, m, rs, e_pri, e_sec, e_al, e_az;
    @(negedge clk);
    rel   = k - base;
    rp    = eff(act_rp);
    e_pri = (rel % rp == rp - 1) ? 1 : 0;
    m     = rel / rp;
    e_sec = 0;
    for (int i = 0; i < N; i++) begin
      rs = eff(act_rs[i]);
      if (act_en[i] && e_pri != 0 && m >= act_ph[i] && ((m - act_ph[i]) % rs == rs - 1))
        e_sec |= (1 << i);
    end
    e_al = (e_pri != 0 && ((e_sec | ~act_en) & ((1 << N) - 1)) == (1 << N) - 1) ? 1 : 0;
    e_az = ((k - az_base) % az_a == az_a - 1) ? 1 : 0;
    check({ctx, "R1 primary strobe"}, int'(pri_tick), e_pri);
    check({ctx, "R2/R3/R4 secondary strobes"}, int'(sec_tick), e_sec);
    check({ctx, "R5 aligned"}, int'(aligned), e_al);
    check({ctx, "R7 auto-zero"}, int'(az_tick), e_az);
    if (e_al != 0 && !same_cfg()) begin
      base = k + 1;
      adopt();
      restarts++;
    end
    if (e_az != 0) begin
      az_base = k + 1;
      az_a    = azf(cur_az);
    end
    k++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; restarts = 0;
    cur_rp = 1; cur_en = 0; cur_az = 0;
    for (int i = 0; i < N; i++) begin cur_rs[i] = 1; cur_ph[i] = 0; end

    // Sweep: ratios 0..3 (0 acts as 1), phases, every enable mask, static config
    for (int rp = 0; rp < 4; rp++) begin
      for (int s = 0; s < 8; s++) begin
        cur_rp = rp;
        cur_en = s;
        cur_az = (s % 3 == 0) ? 0 : ((s % 3 == 1) ? 5 : 20);
        for (int i = 0; i < N; i++) begin
          cur_rs[i] = (s + i) % 4;
          cur_ph[i] = (s * (i + 1) + rp) % 5;
        end
        do_reset();
        for (int c = 0; c < 120; c++) step("");
      end
    end

    // R6: live configuration changes, adopted only at differing alignments
    do_reset();
    for (int c = 0; c < 30; c++) begin
      cur_rp = c % 4;
      cur_en = (c % 7) + 1;
      for (int i = 0; i < N; i++) begin
        cur_rs[i] = (c + 2 * i) % 3 + 1;
        cur_ph[i] = (c + i) % 3;
      end
      if (c % 2 == 0) cur_az = (c % 4 == 0) ? 30 : 3;
      for (int j = 0; j < 23; j++) step("R6 ");
    end
    check("R6 restarts observed", (restarts > 0) ? 1 : 0, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule